// File: doc/BRIEF.md
# Continuation-Stack Fibonacci Engine

This block evaluates the Fibonacci function by doubly recursive descent, without any hardware recursion. The recursion is written as a small set of rewrite rules over a single action register. The action is either "evaluate Fib1(n, c)" or "apply continuation c to value v". Each clock cycle applies exactly one rule. Pending work is kept on an explicit continuation stack held in an inferable on-chip RAM.

Each stack entry stores only a 2-bit continuation tag and one integer. Entries are allocated strictly in address order, so the parent of the entry at pointer s is always s-1. No link field is stored. Pointer 0 stands for the bottom (identity) continuation and is never written.

A caller presents `arg` with a one-cycle `go` while `ready` is high. The caller then waits for `ready` to rise again and reads `result`. If the stack would grow past its last address, the computation is abandoned and a sticky `overflow` flag is raised.

Top module: `fib_cont_engine`

## Requirements
- R1: After reset, `ready` is 1, `result` is 0 and `overflow` is 0.
- R2: An accepted request with `arg` = 0 is evaluated exactly as `arg` = 1.
- R3: For an effective argument n with n <= DEPTH+1, the returned `result` is fib(n), where fib(1) = fib(2) = 1 and fib(n) = fib(n-1) + fib(n-2). The base case n <= 2 produces the value 1 in one rule.
- R4: One rewrite rule is applied per cycle. Let the go-sampling edge be edge 0. Then `ready` rises at edge F(n)+1, where F(1) = F(2) = 1 and F(n) = F(n-1) + F(n-2) + 3. The three extra cycles are one push, one first-call continuation and one second-call pop.
- R5: Continuation tags are 00 for bottom, 01 for after-first-call (holding n) and 10 for after-second-call (holding fib(n-1)). A push at pointer s writes address s+1. Address 0 is never written and always reads as bottom.
- R6: A push attempted while the pointer equals DEPTH-1 aborts the computation. It sets `overflow` to 1, raises `ready`, and sets `result` to 0. This happens exactly when the effective n exceeds DEPTH+1.
- R7: `overflow` stays at 1 while idle and is cleared when the next request is accepted.
- R8: While idle, `ready` and `result` hold their values until the next accepted `go`.
- R9: `go` asserted while a computation is in progress is ignored. It changes neither the result nor the completion time of the running request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| go | input | 1 | Start request, sampled only while `ready` is 1 |
| arg | input | ARG_W | Requested index n |
| ready | output | 1 | 1 while idle; rises when a computation ends |
| result | output | VAL_W | fib(n), or 0 after an overflow |
| overflow | output | 1 | Sticky stack-overflow flag for the last request |

## Verification
The bench builds the engine with DEPTH = 8, ARG_W = 5 and VAL_W = 16. This lets it sweep every possible argument, 0 through 31. Arguments 1 to 9 fit within the stack and are compared against an arithmetic Fibonacci table and the F(n) cycle recurrence. Arguments 10 to 31 drive the descent into the last stack address and must end in overflow.

The small depth also makes the busy-go, hold-while-idle and overflow-clear sequences short enough to exercise directly.

// File: rtl/fibc_pkg.sv
package fibc_pkg;

  // Continuation tags stored in the stack; encoding is fixed by R5.
  typedef enum logic [1:0] {
    TAG_BOTTOM = 2'b00,
    TAG_FIRST  = 2'b01,
    TAG_SECOND = 2'b10,
    TAG_RSVD   = 2'b11
  } ctag_e;

  // Contents of the action register.
  typedef enum logic [1:0] {
    ACT_IDLE = 2'b00,
    ACT_FIB1 = 2'b01,
    ACT_CONT = 2'b10
  } act_e;

endpackage

// File: rtl/fibc_stack_ram.sv
module fibc_stack_ram #(
  parameter int DEPTH  = 64,
  parameter int ENT_W  = 34,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [ENT_W-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [ENT_W-1:0] rdata
);

  // Simple dual-port memory with registered read, so it can map to block RAM.
  logic [ENT_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/fibc_adder.sv
module fibc_adder #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] sum
);

  // Values wrap modulo 2**W.
  assign sum = a + b;

endmodule

// File: rtl/fibc_rules.sv
module fibc_rules
  import fibc_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int ARG_W  = 6,
  parameter int VAL_W  = 32,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int ENT_W = VAL_W + 2
) (
  input  act_e             act_q,
  input  logic [VAL_W-1:0] n_q,
  input  logic [VAL_W-1:0] val_q,
  input  logic [PTR_W-1:0] sp_q,
  input  ctag_e            top_tag,
  input  logic [VAL_W-1:0] top_data,
  input  logic             go,
  input  logic [ARG_W-1:0] arg,
  output act_e             act_d,
  output logic [VAL_W-1:0] n_d,
  output logic [VAL_W-1:0] val_d,
  output logic [PTR_W-1:0] sp_d,
  output logic             we,
  output logic [PTR_W-1:0] waddr,
  output logic [ENT_W-1:0] wdata,
  output logic [PTR_W-1:0] raddr,
  output logic             start,
  output logic             finish,
  output logic             ovf_set
);

  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [VAL_W-1:0] ONE  = VAL_W'(1);
  localparam logic [VAL_W-1:0] TWO  = VAL_W'(2);

  logic [VAL_W-1:0] sum;
  logic [PTR_W-1:0] sp_up;
  logic [PTR_W-1:0] sp_dn;
  logic             at_bottom;

  fibc_adder #(.W(VAL_W)) u_add (
    .a   (top_data),
    .b   (val_q),
    .sum (sum)
  );

  assign sp_up     = sp_q + PTR_W'(1);
  assign sp_dn     = sp_q - PTR_W'(1);
  assign at_bottom = (sp_q == '0) || (top_tag == TAG_BOTTOM) || (top_tag == TAG_RSVD);

  always_comb begin
    act_d   = act_q;
    n_d     = n_q;
    val_d   = val_q;
    sp_d    = sp_q;
    we      = 1'b0;
    waddr   = sp_up;
    wdata   = '0;
    raddr   = sp_q;
    start   = 1'b0;
    finish  = 1'b0;
    ovf_set = 1'b0;
    unique case (act_q)
      ACT_IDLE: begin
        if (go) begin
          // A request for n becomes Fib1(n, bottom); n = 0 is taken as 1.
          start = 1'b1;
          act_d = ACT_FIB1;
          sp_d  = '0;
          n_d   = (arg == '0) ? ONE : VAL_W'(arg);
        end
      end
      ACT_FIB1: begin
        if (n_q <= TWO) begin
          // Base case: Cont(c, 1); start fetching the top entry now.
          act_d = ACT_CONT;
          val_d = ONE;
          raddr = sp_q;
        end else if (sp_q == LAST) begin
          ovf_set = 1'b1;
          finish  = 1'b1;
          act_d   = ACT_IDLE;
        end else begin
          // Push after-first-call(n) and descend to n-1.
          we    = 1'b1;
          waddr = sp_up;
          wdata = {TAG_FIRST, n_q};
          sp_d  = sp_up;
          n_d   = n_q - ONE;
        end
      end
      ACT_CONT: begin
        if (at_bottom) begin
          finish = 1'b1;
          act_d  = ACT_IDLE;
        end else if (top_tag == TAG_FIRST) begin
          // Overwrite with after-second-call(fib(n-1)) and descend to n-2.
          we    = 1'b1;
          waddr = sp_q;
          wdata = {TAG_SECOND, val_q};
          n_d   = top_data - TWO;
          act_d = ACT_FIB1;
        end else begin
          // Pop and continue the parent with the sum.
          val_d = sum;
          sp_d  = sp_dn;
          raddr = sp_dn;
          act_d = ACT_CONT;
        end
      end
      default: begin
        act_d = ACT_IDLE;
      end
    endcase
  end

endmodule

// File: rtl/fib_cont_engine.sv
module fib_cont_engine
  import fibc_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int ARG_W  = 6,
  parameter int VAL_W  = 32,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int ENT_W = VAL_W + 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic [ARG_W-1:0] arg,
  output logic             ready,
  output logic [VAL_W-1:0] result,
  output logic             overflow
);

  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  act_e             act_q, act_d;
  logic [VAL_W-1:0] n_q, n_d, val_q, val_d;
  logic [PTR_W-1:0] sp_q, sp_d;
  logic             ready_q, ovf_q;
  logic [VAL_W-1:0] result_q;

  logic             we;
  logic [PTR_W-1:0] waddr, raddr;
  logic [ENT_W-1:0] wdata, rdata;
  logic             start, finish, ovf_set;
  ctag_e            top_tag;
  logic [VAL_W-1:0] top_data;

  assign top_tag  = ctag_e'(rdata[ENT_W-1 -: 2]);
  assign top_data = rdata[VAL_W-1:0];

  fibc_stack_ram #(.DEPTH(DEPTH), .ENT_W(ENT_W)) u_stack (
    .clk   (clk),
    .we    (we),
    .waddr (waddr),
    .wdata (wdata),
    .raddr (raddr),
    .rdata (rdata)
  );

  fibc_rules #(.DEPTH(DEPTH), .ARG_W(ARG_W), .VAL_W(VAL_W)) u_rules (
    .act_q    (act_q),
    .n_q      (n_q),
    .val_q    (val_q),
    .sp_q     (sp_q),
    .top_tag  (top_tag),
    .top_data (top_data),
    .go       (go),
    .arg      (arg),
    .act_d    (act_d),
    .n_d      (n_d),
    .val_d    (val_d),
    .sp_d     (sp_d),
    .we       (we),
    .waddr    (waddr),
    .wdata    (wdata),
    .raddr    (raddr),
    .start    (start),
    .finish   (finish),
    .ovf_set  (ovf_set)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q    <= ACT_IDLE;
      n_q      <= '0;
      val_q    <= '0;
      sp_q     <= '0;
      ready_q  <= 1'b1;
      ovf_q    <= 1'b0;
      result_q <= '0;
    end else begin
      act_q <= act_d;
      n_q   <= n_d;
      val_q <= val_d;
      sp_q  <= sp_d;
      if (start) begin
        ready_q <= 1'b0;
        ovf_q   <= 1'b0;
      end
      if (finish) begin
        ready_q  <= 1'b1;
        result_q <= ovf_set ? '0 : val_q;
      end
      if (ovf_set) begin
        ovf_q <= 1'b1;
      end
    end
  end

  assign ready    = ready_q;
  assign result   = result_q;
  assign overflow = ovf_q;

  // R4
  push_step_chk: assert property (@(posedge clk) disable iff (rst)
    (act_q == ACT_FIB1 && n_q > VAL_W'(2) && sp_q != LAST)
      |=> (act_q == ACT_FIB1 && sp_q == $past(sp_q) + PTR_W'(1) && n_q == $past(n_q) - VAL_W'(1)));

  // R4
  pop_step_chk: assert property (@(posedge clk) disable iff (rst)
    (act_q == ACT_CONT && sp_q != '0 && top_tag == TAG_SECOND)
      |=> (act_q == ACT_CONT && sp_q == $past(sp_q) - PTR_W'(1)));

  // R3
  base_case_chk: assert property (@(posedge clk) disable iff (rst)
    (act_q == ACT_FIB1 && n_q <= VAL_W'(2)) |=> (act_q == ACT_CONT && val_q == VAL_W'(1)));

  // R5
  bottom_write_chk: assert property (@(posedge clk) disable iff (rst)
    we |-> waddr != '0);

  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ready_q && !go) |=> (ready_q && $stable(result_q)));

  // R7
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (ovf_q && !(ready_q && go)) |=> ovf_q);

  // R6
  ovf_ready_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf_q) |-> (ready_q && result_q == '0));

endmodule

// File: tb/fib_cont_engine_tb.sv
module fib_cont_engine_tb;

  localparam int DEPTH = 8;
  localparam int ARG_W = 5;
  localparam int VAL_W = 16;
  localparam int NMAX  = 31;
  localparam int LIMIT = 20000;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             go  = 1'b0;
  logic [ARG_W-1:0] arg = '0;
  logic             ready;
  logic [VAL_W-1:0] result;
  logic             overflow;

  int total = 0;
  int bad   = 0;
  int fibv [0:NMAX];
  int lat  [0:NMAX];

  always #4 clk = ~clk;

  fib_cont_engine #(.DEPTH(DEPTH), .ARG_W(ARG_W), .VAL_W(VAL_W)) u_dut (
    .clk      (clk),
    .rst      (rst),
    .go       (go),
    .arg      (arg),
    .ready    (ready),
    .result   (result),
    .overflow (overflow)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Issues one request and returns the number of edges until ready rises.
  task automatic run(input int n, output int cycles);
    @(negedge clk);
    arg = ARG_W'(n);
    go  = 1'b1;
    @(negedge clk);
    go  = 1'b0;
    cycles = 0;
    while (!ready && cycles < LIMIT) begin
      @(negedge clk);
      cycles++;
    end
    if (cycles >= LIMIT) begin
      bad++;
      total++;
      $display("FAIL R4 watchdog actual=%0d expected=%0d", cycles, lat[n]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL R4 global watchdog actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int cyc;
    int held;
    fibv[0] = 1; fibv[1] = 1; fibv[2] = 1;
    lat[0] = 1;  lat[1] = 1;  lat[2] = 1;
    for (int k = 3; k <= NMAX; k++) begin
      fibv[k] = (fibv[k-1] + fibv[k-2]) & 16'hFFFF;
      lat[k]  = lat[k-1] + lat[k-2] + 3;
    end

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(ready == 1'b1, "R1 ready", int'(ready), 1);
    check(result == '0, "R1 result", int'(result), 0);
    check(overflow == 1'b0, "R1 overflow", int'(overflow), 0);

    // Full sweep: R2 (n=0), R3 values, R4 latency, R6 overflow region
    for (int n = 0; n <= NMAX; n++) begin
      int eff;
      eff = (n == 0) ? 1 : n;
      run(n, cyc);
      if (eff <= DEPTH + 1) begin
        if (n == 0) check(result == 16'(fibv[1]), "R2 zero arg", int'(result), fibv[1]);
        else        check(result == 16'(fibv[eff]), "R3 value", int'(result), fibv[eff]);
        check(cyc == lat[eff] + 1, "R4 latency", cyc, lat[eff] + 1);
        check(overflow == 1'b0, "R6 no overflow", int'(overflow), 0);
      end else begin
        check(overflow == 1'b1, "R6 overflow set", int'(overflow), 1);
        check(result == '0, "R6 result zero", int'(result), 0);
        check(ready == 1'b1, "R6 ready", int'(ready), 1);
      end
    end

    // R7 sticky while idle, then cleared by the next request
    run(12, cyc);
    repeat (5) @(negedge clk);
    check(overflow == 1'b1, "R7 sticky", int'(overflow), 1);
    run(4, cyc);
    check(overflow == 1'b0, "R7 cleared", int'(overflow), 0);
    check(result == 16'(fibv[4]), "R7 result after clear", int'(result), fibv[4]);

    // R8 hold while idle, arg changes but go stays low
    run(8, cyc);
    arg = 5'd3;
    repeat (10) @(negedge clk);
    held = int'(result);
    check(result == 16'(fibv[8]) && ready, "R8 hold", held, fibv[8]);

    // R9 go during a busy run is ignored; R5 stack reuse after second-call
    @(negedge clk);
    arg = 5'd7;
    go  = 1'b1;
    @(negedge clk);
    go  = 1'b0;
    cyc = 0;
    repeat (3) begin @(negedge clk); cyc++; end
    arg = 5'd3;
    go  = 1'b1;
    @(negedge clk);
    cyc++;
    go  = 1'b0;
    while (!ready && cyc < LIMIT) begin
      @(negedge clk);
      cyc++;
    end
    check(result == 16'(fibv[7]), "R9 busy go result", int'(result), fibv[7]);
    check(cyc == lat[7] + 1, "R9 busy go latency", cyc, lat[7] + 1);

    // R5 deepest legal request twice in a row reuses the same addresses
    run(DEPTH + 1, cyc);
    check(result == 16'(fibv[DEPTH+1]), "R5 deepest", int'(result), fibv[DEPTH+1]);
    run(DEPTH + 1, cyc);
    check(result == 16'(fibv[DEPTH+1]) && !overflow, "R5 deepest repeat", int'(result), fibv[DEPTH+1]);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule